// File: doc/BRIEF.md
# Double-Edge Pulse Width Capture

This unit timestamps both edges of a pulse on one input pin. It uses a free-running 16-bit time-base bus that is generated elsewhere. The pin first passes through a synchronizer. A qualified leading edge copies the bus into a staging register. The matching trailing edge does two things in the same clock: it copies the bus into the trailing-edge register, and it moves the staged leading timestamp into a holding register. Software reads the holding and trailing registers and subtracts them to get the pulse width in time-base ticks.

Because the leading timestamp is latched twice, the staging register is free again in the very next clock. A new pulse can begin at once, while software still has a full input period to read the previous pair. A control register picks which pin transition counts as leading, and it enables an interrupt for a completed pair and a separate interrupt for a leading edge. A status register holds the pair-ready, leading-seen and overrun flags, and each is cleared by writing 1 to it.

Top module: `pulse_width_capture`

## Requirements
- R1: After reset, every readable register is zero, `irq` is low, and the unit waits for a leading edge.
- R2: The pin goes through two synchronizer flops. The bus value stored for an edge is the one present at the third rising clock edge after the pin changes. A leading edge writes that value to the staging register (address 4).
- R3: A trailing edge that follows a captured leading edge writes the bus to the trailing register (address 2). In the same cycle it copies the staging register into the holding register (address 3), so that trailing minus holding equals the pulse length in clocks when the bus counts once per clock.
- R4: Control bit 0 selects the polarity. With 0, a rising transition is leading and a falling one is trailing; with 1, the roles are swapped.
- R5: Each completed pair sets status bit 0. `irq` is high while status bit 0 and control bit 1 are both set.
- R6: Each leading edge sets status bit 1. `irq` is high while status bit 1 and control bit 2 are both set; with control bit 2 clear, a leading edge alone leaves `irq` low.
- R7: A trailing edge with no leading edge captured since the last completed pair is ignored. The trailing register, holding register and status bit 0 keep their values.
- R8: Writing the status register (address 1) clears each flag whose data bit is 1 and leaves every flag whose data bit is 0.
- R9: A completed pair that arrives while status bit 0 is still set sets the overrun flag, status bit 2.
- R10: With control bits 1 and 2 clear, `irq` stays low, yet the trailing and holding registers still update on every pulse.
- R11: A leading edge in the clock right after a trailing edge is captured into the staging register and leaves the pair just stored unchanged.
- R12: Control is at address 0 and status at address 1. Writes to addresses 2 to 4 are ignored, and any unused address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous pulse input |
| tbus | input | 16 | Shared time-base counter bus |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after a one-clock pulse and a leading edge that arrives one clock after a trailing edge. A design that reused the staging register too late would lose the new leading stamp or corrupt the stored pair. It sends a trailing edge with no leading edge before it; a design that fails to track that state would store a bogus width and raise the ready flag. It also covers overrun on an uncleared flag, partial write-1-to-clear, both polarities, and the leading-only interrupt. In those cases a design that set the wrong flag or mixed up the interrupt sources would show a wrong `irq` level.

// File: rtl/pwc_pkg.sv
// Package: shared address map and control layout for the pulse width capture unit.
// Assumes a 3-bit register address space.
package pwc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL       = 3'd0,
        ADR_STAT       = 3'd1,
        ADR_TRAIL      = 3'd2,
        ADR_LEAD_HOLD  = 3'd3,
        ADR_LEAD_STAGE = 3'd4
    } pwc_addr_e;

    typedef struct packed {
        logic lead_ie;
        logic pair_ie;
        logic lead_fall;
    } pwc_ctrl_t;

    typedef struct packed {
        logic overrun;
        logic lead_seen;
        logic pair_ready;
    } pwc_stat_t;
endpackage

// File: rtl/pwc_edge_detect.sv
// Module: synchronizes the pin and produces one-cycle leading and trailing
// edge strobes for the selected polarity.
// Assumes pin_in is asynchronous; SYNC_STAGES >= 2.
module pwc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic lead_fall,
    output logic lead_ev,
    output logic trail_ev
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall;

    // Synchronizer chain built stage by stage.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= pin_in;
                end
            end else begin : g_next
                // Later stages shift the sample along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Map raw transitions onto leading and trailing per polarity.
    always_comb begin
        rise     = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall     = ~sync_q[SYNC_STAGES-1] & prev_q;
        lead_ev  = lead_fall ? fall : rise;
        trail_ev = lead_fall ? rise : fall;
    end
endmodule

// File: rtl/pwc_capture.sv
// Module: the three timestamp registers plus the armed state. The leading
// stamp is staged, then moved to the holding register on the trailing edge.
// Assumes lead_ev and trail_ev are never high in the same cycle.
module pwc_capture #(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lead_ev,
    input  logic            trail_ev,
    input  logic [TB_W-1:0] tbus,
    output logic [TB_W-1:0] stage_q,
    output logic [TB_W-1:0] hold_q,
    output logic [TB_W-1:0] trail_q,
    output logic            armed_q,
    output logic            pair_done
);
    // A pair completes only on a trailing edge after a captured leading edge.
    assign pair_done = trail_ev & armed_q;

    // Staging register: takes the bus on every leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q <= '0;
        else if (lead_ev) stage_q <= tbus;
    end

    // Pair registers: trailing stamp and hold move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            trail_q <= '0;
        end else if (pair_done) begin
            hold_q  <= stage_q;
            trail_q <= tbus;
        end
    end

    // Armed state: set by a leading edge, cleared by a completed pair.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (lead_ev)   armed_q <= 1'b1;
        else if (pair_done) armed_q <= 1'b0;
    end
endmodule

// File: rtl/pwc_regs.sv
// Module: register port, control bits, write-1-to-clear status flags and the
// interrupt request. Read data is a combinational decode of the address.
// Assumes one write per cycle; a set event wins over a clear in the same cycle.
module pwc_regs
    import pwc_pkg::*;
#(
    parameter int TB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [TB_W-1:0]   reg_wdata,
    input  logic              lead_ev,
    input  logic              pair_done,
    input  logic [TB_W-1:0]   stage_q,
    input  logic [TB_W-1:0]   hold_q,
    input  logic [TB_W-1:0]   trail_q,
    output pwc_ctrl_t         ctrl_q,
    output pwc_stat_t         stat_q,
    output logic [TB_W-1:0]   reg_rdata,
    output logic              irq
);
    localparam int CTRL_W = $bits(pwc_ctrl_t);
    localparam int STAT_W = $bits(pwc_stat_t);

    logic      wr_ctrl, wr_stat;
    pwc_stat_t clr;

    // Decode the write strobes.
    always_comb begin
        wr_ctrl = reg_we && (reg_addr == ADR_CTRL);
        wr_stat = reg_we && (reg_addr == ADR_STAT);
        clr     = wr_stat ? pwc_stat_t'(reg_wdata[STAT_W-1:0]) : '0;
    end

    // Control register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= pwc_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Status flags: set by events, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (pair_done)           stat_q.pair_ready <= 1'b1;
            else if (clr.pair_ready) stat_q.pair_ready <= 1'b0;
            if (lead_ev)             stat_q.lead_seen  <= 1'b1;
            else if (clr.lead_seen)  stat_q.lead_seen  <= 1'b0;
            if (pair_done && stat_q.pair_ready) stat_q.overrun <= 1'b1;
            else if (clr.overrun)               stat_q.overrun <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL:       reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADR_STAT:       reg_rdata[STAT_W-1:0] = stat_q;
            ADR_TRAIL:      reg_rdata = trail_q;
            ADR_LEAD_HOLD:  reg_rdata = hold_q;
            ADR_LEAD_STAGE: reg_rdata = stage_q;
            default:        reg_rdata = '0;
        endcase
    end

    // Interrupt request from either enabled source.
    always_comb begin
        irq = (stat_q.pair_ready & ctrl_q.pair_ie) | (stat_q.lead_seen & ctrl_q.lead_ie);
    end
endmodule

// File: rtl/pulse_width_capture.sv
// Module: top of the double-edge pulse width capture unit. It ties the edge
// detector, the timestamp registers and the register port together.
// Assumes tbus is synchronous to clk.
module pulse_width_capture
    import pwc_pkg::*;
#(
    parameter int TB_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic [TB_W-1:0]   tbus,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [TB_W-1:0]   reg_wdata,
    output logic [TB_W-1:0]   reg_rdata,
    output logic              irq
);
    logic            lead_ev, trail_ev, armed_q, pair_done;
    logic [TB_W-1:0] stage_q, hold_q, trail_q;
    pwc_ctrl_t       ctrl_q;
    pwc_stat_t       stat_q;

    pwc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .lead_fall(ctrl_q.lead_fall),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev)
    );

    pwc_capture #(.TB_W(TB_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev),
        .tbus     (tbus),
        .stage_q  (stage_q),
        .hold_q   (hold_q),
        .trail_q  (trail_q),
        .armed_q  (armed_q),
        .pair_done(pair_done)
    );

    pwc_regs #(.TB_W(TB_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .lead_ev  (lead_ev),
        .pair_done(pair_done),
        .stage_q  (stage_q),
        .hold_q   (hold_q),
        .trail_q  (trail_q),
        .ctrl_q   (ctrl_q),
        .stat_q   (stat_q),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );
endmodule

// File: rtl/pwc_checker.sv
// Module: assertion checker bound into pulse_width_capture. It watches the
// edge strobes, the timestamp registers and the flags.
module pwc_checker #(
    parameter int TB_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lead_ev,
    input logic            trail_ev,
    input logic            armed_q,
    input logic [TB_W-1:0] tbus,
    input logic [TB_W-1:0] stage_q,
    input logic [TB_W-1:0] hold_q,
    input logic [TB_W-1:0] trail_q,
    input logic            pair_ready,
    input logic            overrun,
    input logic            pair_ie,
    input logic            lead_ie,
    input logic            irq
);
    assert_lead_stamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lead_ev |=> stage_q == $past(tbus));

    assert_pair_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_ev && armed_q) |=> (hold_q == $past(stage_q)) && (trail_q == $past(tbus)) && pair_ready);

    assert_orphan_trail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_ev && !armed_q) |=> $stable(hold_q) && $stable(trail_q));

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_ev && armed_q && pair_ready) |=> overrun);

    assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_ie && !lead_ie) |-> !irq);

    assert_edges_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_ev && trail_ev));
endmodule

bind pulse_width_capture pwc_checker #(.TB_W(TB_W)) u_pwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lead_ev   (lead_ev),
    .trail_ev  (trail_ev),
    .armed_q   (armed_q),
    .tbus      (tbus),
    .stage_q   (stage_q),
    .hold_q    (hold_q),
    .trail_q   (trail_q),
    .pair_ready(stat_q.pair_ready),
    .overrun   (stat_q.overrun),
    .pair_ie   (ctrl_q.pair_ie),
    .lead_ie   (ctrl_q.lead_ie),
    .irq       (irq)
);

// File: tb/test_pulse_width_capture.sv
module test_pulse_width_capture;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // Each entry: {lead_fall, pulse length in clocks}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'd5}, {1'b0, 16'd1}, {1'b1, 16'd7}, {1'b1, 16'd40}, {1'b0, 16'd200}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] tbus = 16'h1234;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    pulse_width_capture i_pulse_width_capture (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tbus(tbus),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tbus <= tbus + 16'd1;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive the pin to lvl at a negedge; return the bus value captured for it.
    task automatic drive(input logic lvl, output logic [15:0] stamp);
        @(negedge clk);
        pin_in = lvl;
        #1 stamp = tbus + 16'd2;
    endtask

    task automatic pulse(input logic pol, input int width, output logic [15:0] tl, output logic [15:0] tt);
        logic [15:0] dummy;
        drive(~pol, tl);
        idle(width - 1);
        drive(pol, tt);
        dummy = tt;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v, tl, tt, tl2, tt2, s;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 / R12: reset values and address map
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk("R1 reset read", v, 16'h0);
        end
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);

        // Table-driven pulses (R2, R3, R4, R5)
        for (int k = 0; k < NVEC; k++) begin
            logic pol;
            int   w;
            pol = VEC[k][16];
            w   = int'(VEC[k][15:0]);
            @(negedge clk); pin_in = pol;
            idle(4);
            wr(3'd0, {13'h0, 1'b0, 1'b1, pol});
            idle(2);
            wr(3'd1, 16'h7);
            pulse(pol, w, tl, tt);
            idle(5);
            rd(3'd3, v); chk("R2 lead stamp", v, tl);
            rd(3'd2, v); chk("R3 trail stamp", v, tt);
            rd(3'd2, s); rd(3'd3, v); chk("R3 width", s - v, w[15:0]);
            rd(3'd1, v); chk("R5 pair flag and no overrun", v & 16'h5, 16'h1);
            chk("R5 irq", {15'h0, irq}, 16'h1);
            chk(pol ? "R4 falling lead" : "R4 rising lead", v & 16'h2, 16'h2);
        end

        // R9: second pair with flag still set; R8 partial clear
        pulse(1'b0, 6, tl, tt);
        idle(5);
        rd(3'd1, v); chk("R9 overrun", v, 16'h7);
        wr(3'd1, 16'h0);
        rd(3'd1, v); chk("R8 write zero keeps", v, 16'h7);
        wr(3'd1, 16'h2);
        rd(3'd1, v); chk("R8 clear lead only", v, 16'h5);
        wr(3'd1, 16'h5);
        rd(3'd1, v); chk("R8 clear rest", v, 16'h0);

        // R12: writes to capture registers ignored
        rd(3'd2, s);
        wr(3'd2, 16'hBEEF);
        rd(3'd2, v); chk("R12 trail read-only", v, s);

        // R10: polled mode
        wr(3'd0, 16'h0);
        pulse(1'b0, 9, tl, tt);
        idle(5);
        chk("R10 irq quiet", {15'h0, irq}, 16'h0);
        rd(3'd2, v); chk("R10 trail updates", v, tt);
        rd(3'd3, v); chk("R10 hold updates", v, tl);
        wr(3'd1, 16'h7);

        // R6: leading-edge interrupt only
        wr(3'd0, 16'h4);
        drive(1'b1, tl);
        idle(4);
        chk("R6 lead irq", {15'h0, irq}, 16'h1);
        rd(3'd4, v); chk("R6 stage stamp", v, tl);
        drive(1'b0, tt);
        idle(4);
        wr(3'd1, 16'h7);

        // R7: orphan trailing edge (lead falling, pin low, raise pin)
        wr(3'd0, 16'h3);
        idle(3);
        rd(3'd2, s);
        drive(1'b1, tt);
        idle(5);
        rd(3'd2, v); chk("R7 trail unchanged", v, s);
        rd(3'd1, v); chk("R7 no pair flag", v & 16'h1, 16'h0);
        chk("R7 irq quiet", {15'h0, irq}, 16'h0);

        // R11: back-to-back leading edge right after trailing
        wr(3'd0, 16'h2);
        @(negedge clk); pin_in = 1'b0;
        idle(5);
        wr(3'd1, 16'h7);
        drive(1'b1, tl);
        idle(2);
        drive(1'b0, tt);
        drive(1'b1, tl2);
        idle(5);
        rd(3'd3, v); chk("R11 hold kept", v, tl);
        rd(3'd2, v); chk("R11 trail kept", v, tt);
        rd(3'd4, v); chk("R11 new stage", v, tl2);
        drive(1'b0, tt2);
        idle(5);
        rd(3'd3, v); chk("R11 second pair hold", v, tl2);
        rd(3'd2, v); chk("R11 second pair trail", v, tt2);

        // R1: reset clears everything again
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        rd(3'd2, v); chk("R1 trail after reset", v, 16'h0);
        rd(3'd1, v); chk("R1 stat after reset", v, 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule